// File: doc/BRIEF.md
# Ethernet Frame Check Sequence Inserter

This block sits on a byte-wide stream carrying an Ethernet frame body: destination and source addresses, type, and payload. It passes every body byte through unchanged. After the last byte it adds the 32-bit frame check sequence.

The check value is the common reflected CRC-32. It starts from all ones, uses polynomial 0xEDB88320 in shift-right form, and is inverted at the end. It covers every byte the block sends before it.

When the `pad_en` input is high, a body shorter than `MIN_BODY` bytes (60 by default) is followed by zero bytes until exactly `MIN_BODY` bytes have gone out. The check sequence then follows. Both the input and the output use a valid/ready handshake. Stalls from either side are tolerated at any beat.

The controller has three states:
- `ST_BODY` passes body beats straight through. The input ready follows the output ready.
- `ST_PAD` emits zero bytes.
- `ST_FCS` emits the four check bytes.

The controller has these transitions:
- `BODY_TO_PAD`: the last body beat is accepted while padding is on and the count is still short.
- `BODY_TO_FCS`: the last body beat is accepted with no padding needed.
- `PAD_TO_FCS`: the pad beat that reaches `MIN_BODY` is accepted.
- `FCS_TO_BODY`: the fourth check byte is accepted. The CRC register, byte counter and error flag are then re-armed for the next frame.

The error marker on the input (`s_user`) is collected across the frame. It is reported with the final output beat.

Top module: `fcs_inserter`

## Requirements
- R1: The output frame is the input body, byte for byte and in order, followed by exactly four check bytes. `m_last` is high only on the fourth check byte.
- R2: The check value is the reflected CRC-32 (polynomial 0xEDB88320, initial value 0xFFFFFFFF, final inversion) over every byte sent before it in the frame. For the ASCII string "123456789" it is 0xCBF43926.
- R3: The 32-bit check value leaves least-significant byte first: bits 7:0, then 15:8, then 23:16, then 31:24.
- R4: Bodies of every length from 1 to 17 bytes produce correct output. This includes a one-byte body whose first beat is also its last.
- R5: With `pad_en` high, a body shorter than `MIN_BODY` bytes is followed by zero bytes so that exactly `MIN_BODY` bytes precede the check value. The original bytes are unchanged at the start.
- R6: With `pad_en` high, the check value covers the pad bytes as well as the body.
- R7: With `pad_en` high, a body of `MIN_BODY` bytes or more gets no pad bytes.
- R8: Output is correct when the source inserts idle cycles between body beats.
- R9: Output is correct when the sink drops `m_ready` in mid-frame. While a pad or check beat is stalled, `m_valid`, `m_data` and `m_last` hold.
- R10: `s_ready` is low during every pad beat and every check beat.
- R11: The CRC restarts from all ones for each frame. A frame offered immediately after another gets its own correct check value.
- R12: `m_user` is high on the fourth check byte when any accepted body beat of that frame had `s_user` high. It is low on every other output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pad_en | input | 1 | Enables zero padding to `MIN_BODY` bytes; held stable while a frame is in flight |
| s_data | input | 8 | Body byte in |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with `s_valid` |
| s_last | input | 1 | Marks the last body byte |
| s_user | input | 1 | Error marker for the frame |
| m_data | output | 8 | Output byte |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Sink accepts the output beat |
| m_last | output | 1 | Marks the fourth check byte |
| m_user | output | 1 | Frame error marker, on the last beat |

## Verification
The bench builds the block with its defaults, `MIN_BODY` = 60 and the standard reflected polynomial. Padding is therefore switched at run time through `pad_en`, and one instance covers both the plain and the padded path.

A 60-byte minimum makes the three pad boundaries reachable with short frames: 59 bytes (one pad byte), 60 bytes and 61 bytes. The 1-to-17-byte sweep is run three ways: with a free-flowing stream, with idle cycles at the source, and with a stalling sink.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 32;
    localparam int FCS_BYTES = CRC_W / BYTE_W;

    typedef enum logic [1:0] {
        ST_BODY = 2'd0,
        ST_PAD  = 2'd1,
        ST_FCS  = 2'd2
    } fcs_state_t;

endpackage

// File: rtl/fcs_crc32.sv
module fcs_crc32 #(
    parameter int            CRC_W = 32,
    parameter int            BYTE_W = 8,
    parameter logic [31:0]   POLY = 32'hEDB88320
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              advance,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc_q
);

    localparam logic [CRC_W-1:0] SEED = {CRC_W{1'b1}};

    logic [CRC_W-1:0] crc_next;

    // reflected, bit-serial update unrolled over one byte
    always_comb begin
        crc_next = crc_q;
        for (int b = 0; b < BYTE_W; b++) begin
            if (crc_next[0] ^ din[b])
                crc_next = (crc_next >> 1) ^ POLY[CRC_W-1:0];
            else
                crc_next = crc_next >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart)
            crc_q <= SEED;
        else if (advance)
            crc_q <= crc_next;
    end

endmodule

// File: rtl/fcs_len_tracker.sv
module fcs_len_tracker #(
    parameter int MIN_BODY = 60,
    localparam int CNT_W = $clog2(MIN_BODY + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] count_q,
    output logic             short_after_step
);

    localparam logic [CNT_W:0] MIN_V = (CNT_W+1)'(MIN_BODY);

    logic [CNT_W:0] count_plus;

    assign count_plus       = {1'b0, count_q} + {{CNT_W{1'b0}}, 1'b1};
    assign short_after_step = (count_plus < MIN_V);

    always_ff @(posedge clk) begin
        if (rst || clear)
            count_q <= '0;
        else if (step && (count_plus <= MIN_V))
            count_q <= count_plus[CNT_W-1:0];
    end

    // R5: the count saturates at the minimum body length
    assert_count_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        {1'b0, count_q} <= MIN_V);

endmodule

// File: rtl/fcs_inserter.sv
module fcs_inserter
    import fcs_pkg::*;
#(
    parameter int          MIN_BODY = 60,
    parameter logic [31:0] CRC_POLY = 32'hEDB88320
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pad_en,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic              s_last,
    input  logic              s_user,
    output logic [BYTE_W-1:0] m_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic              m_last,
    output logic              m_user
);

    localparam int CNT_W = $clog2(MIN_BODY + 1);
    localparam int IDX_W = $clog2(FCS_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FCS_BYTES - 1);

    fcs_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             err_q;

    logic [CRC_W-1:0] crc_q;
    logic [CNT_W-1:0] byte_cnt;
    logic             short_after;

    logic             out_fire;
    logic             crc_adv;
    logic [BYTE_W-1:0] crc_din;
    logic             frame_done;

    assign out_fire   = m_valid && m_ready;
    assign frame_done = out_fire && (state_q == ST_FCS) && (idx_q == IDX_LAST);

    assign crc_adv = out_fire && (state_q != ST_FCS);
    assign crc_din = (state_q == ST_BODY) ? s_data : '0;

    fcs_crc32 #(
        .CRC_W (CRC_W),
        .BYTE_W(BYTE_W),
        .POLY  (CRC_POLY)
    ) u_crc (
        .clk    (clk),
        .rst    (rst),
        .restart(frame_done),
        .advance(crc_adv),
        .din    (crc_din),
        .crc_q  (crc_q)
    );

    fcs_len_tracker #(
        .MIN_BODY(MIN_BODY)
    ) u_len (
        .clk             (clk),
        .rst             (rst),
        .clear           (frame_done),
        .step            (crc_adv),
        .count_q         (byte_cnt),
        .short_after_step(short_after)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BODY: begin
                if (out_fire && s_last)
                    state_d = (pad_en && short_after) ? ST_PAD : ST_FCS;
            end
            ST_PAD: begin
                if (out_fire && !short_after)
                    state_d = ST_FCS;
            end
            ST_FCS: begin
                if (frame_done)
                    state_d = ST_BODY;
            end
            default: state_d = ST_BODY;
        endcase
    end

    // state register and per-frame bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BODY;
            idx_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (frame_done)
                idx_q <= '0;
            else if (out_fire && state_q == ST_FCS)
                idx_q <= idx_q + 1'b1;
            if (frame_done)
                err_q <= 1'b0;
            else if (out_fire && state_q == ST_BODY && s_user)
                err_q <= 1'b1;
        end
    end

    // output logic
    always_comb begin
        s_ready = 1'b0;
        m_valid = 1'b0;
        m_data  = '0;
        m_last  = 1'b0;
        m_user  = 1'b0;
        unique case (state_q)
            ST_BODY: begin
                s_ready = m_ready;
                m_valid = s_valid;
                m_data  = s_data;
            end
            ST_PAD: begin
                m_valid = 1'b1;
            end
            ST_FCS: begin
                m_valid = 1'b1;
                m_data  = ~crc_q[idx_q*BYTE_W +: BYTE_W];
                m_last  = (idx_q == IDX_LAST);
                m_user  = (idx_q == IDX_LAST) && err_q;
            end
            default: ;
        endcase
    end

    // R10: input is blocked while tail beats go out
    assert_tail_blocks_input_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_BODY) |-> !s_ready);

    // R9: a stalled tail beat holds its value
    assert_tail_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_BODY && m_valid && !m_ready) |=>
            (m_valid && $stable(m_data) && $stable(m_last)));

    // R1: a completed frame returns the controller to body state
    assert_last_ends_frame_R1: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_ready && m_last) |=> (state_q == ST_BODY));

    // R11: the CRC register is re-armed after each frame
    assert_crc_rearmed_R11: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_ready && m_last) |=> (crc_q == {CRC_W{1'b1}}));

    // R7: padding never runs past the minimum body length
    assert_pad_below_min_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PAD) |-> ({1'b0, byte_cnt} < (CNT_W+1)'(MIN_BODY)));

    // R1: the last body beat never leaves the controller in body state
    assert_body_last_leaves_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BODY && s_valid && s_ready && s_last) |=> (state_q != ST_BODY));

endmodule

// File: tb/fcs_inserter_test.sv
module fcs_inserter_test;

    localparam int CLK_PERIOD = 10;
    localparam int MIN_BODY = 60;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pad_en = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_valid = 1'b0;
    logic       s_ready;
    logic       s_last = 1'b0;
    logic       s_user = 1'b0;
    logic [7:0] m_data;
    logic       m_valid;
    logic       m_ready = 1'b1;
    logic       m_last;
    logic       m_user;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcs_inserter #(.MIN_BODY(MIN_BODY)) uut (
        .clk(clk), .rst(rst), .pad_en(pad_en),
        .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .s_last(s_last), .s_user(s_user),
        .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready),
        .m_last(m_last), .m_user(m_user)
    );

    // stimulus queues
    logic [7:0] drv_data[$];
    logic       drv_last[$];
    logic       drv_user[$];

    // expected output, per beat; kind 0 body, 1 pad, 2 check byte
    logic [7:0] exp_data[$];
    logic       exp_last[$];
    logic       exp_user[$];
    logic       exp_tail[$];
    int         exp_kind[$];

    // captured output
    logic [7:0] got_data[$];
    logic       got_last[$];
    logic       got_user[$];
    logic       got_rdy[$];

    function automatic logic [31:0] crc_upd(logic [31:0] c, logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ 32'hEDB88320;
            else             c = c >> 1;
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_q();
        drv_data.delete(); drv_last.delete(); drv_user.delete();
        exp_data.delete(); exp_last.delete(); exp_user.delete();
        exp_tail.delete(); exp_kind.delete();
        got_data.delete(); got_last.delete(); got_user.delete(); got_rdy.delete();
    endtask

    task automatic add_frame(input int len, input int seed, input bit err, input bit pad);
        logic [31:0] c = 32'hFFFFFFFF;
        int body = 0;
        for (int i = 0; i < len; i++) begin
            logic [7:0] b = 8'((seed + i) & 255);
            drv_data.push_back(b);
            drv_last.push_back(i == len - 1);
            drv_user.push_back(err && (i == len - 1));
            exp_data.push_back(b); exp_last.push_back(0); exp_user.push_back(0);
            exp_tail.push_back(0); exp_kind.push_back(0);
            c = crc_upd(c, b);
            body++;
        end
        while (pad && body < MIN_BODY) begin
            exp_data.push_back(8'h00); exp_last.push_back(0); exp_user.push_back(0);
            exp_tail.push_back(1); exp_kind.push_back(1);
            c = crc_upd(c, 8'h00);
            body++;
        end
        c = ~c;
        for (int k = 0; k < 4; k++) begin
            exp_data.push_back(c[8*k +: 8]); exp_last.push_back(k == 3);
            exp_user.push_back(err && (k == 3));
            exp_tail.push_back(1); exp_kind.push_back(2);
        end
    endtask

    task automatic drive_all(input bit gap);
        for (int i = 0; i < drv_data.size(); i++) begin
            bit acc = 0;
            if (gap && (i % 2 == 1)) begin
                repeat (2) begin
                    @(negedge clk);
                    s_valid = 1'b0;
                end
            end
            while (!acc) begin
                @(negedge clk);
                s_valid = 1'b1; s_data = drv_data[i];
                s_last = drv_last[i]; s_user = drv_user[i];
                #1;
                acc = s_ready;
            end
        end
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0; s_user = 1'b0;
    endtask

    task automatic collect_all(input bit stall);
        int cyc = 0;
        int guard = 0;
        while (got_data.size() < exp_data.size() && guard < 5000) begin
            @(negedge clk);
            m_ready = stall ? (cyc % 3 == 0) : 1'b1;
            cyc++; guard++;
            #1;
            if (m_valid && m_ready) begin
                got_data.push_back(m_data); got_last.push_back(m_last);
                got_user.push_back(m_user); got_rdy.push_back(s_ready);
            end
        end
        @(negedge clk);
        m_ready = 1'b1;
    endtask

    task automatic run_and_check(input bit gap, input bit stall, input string tag);
        int bad_d = -1, bad_l = -1, bad_u = -1, bad_r = -1;
        int n;
        fork
            drive_all(gap);
            collect_all(stall);
        join
        check(got_data.size() == exp_data.size(), "R1", {tag, " beat count"},
              got_data.size(), exp_data.size());
        n = (got_data.size() < exp_data.size()) ? got_data.size() : exp_data.size();
        for (int i = 0; i < n; i++) begin
            if (bad_d < 0 && got_data[i] !== exp_data[i]) bad_d = i;
            if (bad_l < 0 && got_last[i] !== exp_last[i]) bad_l = i;
            if (bad_u < 0 && got_user[i] !== exp_user[i]) bad_u = i;
            if (bad_r < 0 && exp_tail[i] && got_rdy[i] !== 1'b0) bad_r = i;
        end
        if (bad_d < 0)
            check(1, "R1", tag, 0, 0);
        else if (exp_kind[bad_d] == 2)
            check(0, "R2 R3", {tag, " check byte"}, got_data[bad_d], exp_data[bad_d]);
        else if (exp_kind[bad_d] == 1)
            check(0, "R5 R6", {tag, " pad byte"}, got_data[bad_d], exp_data[bad_d]);
        else
            check(0, "R1", {tag, " body byte"}, got_data[bad_d], exp_data[bad_d]);
        check(bad_l < 0, "R1", {tag, " last flag"},
              bad_l < 0 ? 0 : got_last[bad_l], bad_l < 0 ? 0 : exp_last[bad_l]);
        check(bad_u < 0, "R12", {tag, " user flag"},
              bad_u < 0 ? 0 : got_user[bad_u], bad_u < 0 ? 0 : exp_user[bad_u]);
        check(bad_r < 0, "R10", {tag, " s_ready in tail"},
              bad_r < 0 ? 0 : got_rdy[bad_r], 0);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        check(m_valid == 1'b0, "R1", "reset m_valid", m_valid, 0);
        check(s_ready == 1'b1, "R10", "reset s_ready", s_ready, 1);
    endtask

    task automatic t_crc_anchor();
        logic [31:0] c = 32'hFFFFFFFF;
        string s = "123456789";
        for (int i = 0; i < 9; i++) c = crc_upd(c, s[i]);
        check(~c == 32'hCBF43926, "R2", "bench crc anchor", ~c, 32'hCBF43926);
    endtask

    task automatic t_short_sweep(input bit pad);
        for (int len = 1; len <= 17; len++) begin
            for (int mode = 0; mode < 3; mode++) begin
                clear_q();
                pad_en = pad;
                add_frame(len, len * 7, 0, pad);
                run_and_check(mode == 1, mode == 2,
                    $sformatf("%s len=%0d mode=%0d", pad ? "R5 R6 padded" : "R4 R8 R9 short",
                              len, mode));
            end
        end
    endtask

    task automatic t_pad_edges();
        int lens[3] = '{59, 60, 61};
        foreach (lens[i]) begin
            clear_q();
            pad_en = 1'b1;
            add_frame(lens[i], 3, 0, 1);
            run_and_check(0, 1, $sformatf("R7 pad edge len=%0d", lens[i]));
        end
    endtask

    task automatic t_back_to_back(input bit pad);
        clear_q();
        pad_en = pad;
        add_frame(5, 40, 0, pad);
        add_frame(1, 90, 0, pad);
        add_frame(12, 200, 0, pad);
        run_and_check(0, 0, pad ? "R11 back to back padded" : "R11 back to back");
    endtask

    task automatic t_error_flag();
        clear_q();
        pad_en = 1'b0;
        add_frame(6, 11, 1, 0);
        add_frame(3, 12, 0, 0);
        run_and_check(1, 1, "R12 error marker");
    endtask

    task automatic t_long_plain();
        clear_q();
        pad_en = 1'b0;
        add_frame(64, 0, 0, 0);
        run_and_check(1, 0, "R1 long plain");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_crc_anchor();
        t_short_sweep(0);
        t_short_sweep(1);
        t_pad_edges();
        t_back_to_back(0);
        t_back_to_back(1);
        t_error_flag();
        t_long_plain();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule